// File: doc/BRIEF.md
# CAN Controller SPI Command Engine

This block is the serial front end of a CAN controller peripheral. An external host drives chip select, serial clock and data in SPI mode 0: clock idle low, data captured on the rising edge, MSB first, eight bits per byte. The block decodes the first byte of each chip-select frame as an instruction and uses it to reach a 128-byte register space. That space holds the mode request and mode report registers, the interrupt enable and flag registers, three transmit buffers and two receive buffers.

Besides plain read and write, the engine offers several shorter paths. A masked bit update changes only chosen bits of a register. Dedicated opcodes start a burst directly at a transmit or receive buffer's first identifier byte. A one-byte opcode raises the send request of any set of transmit buffers. A receive-buffer read releases the matching receive-full flag when chip select rises. A reset opcode restores the power-up contents. An active-low interrupt line reflects the enabled flags.

On the peripheral side, a byte-write port and a flag-set port let the rest of the controller, or a testbench, deposit received frames and raise flags. The serial pins are sampled with the block clock, which must run several times faster than the serial clock.

Top module: `canspi_engine`

## Requirements
- R1: After hardware reset, register 0x0E reads 0x80 (configuration mode reported in bits 7:5), register 0x0F reads 0x87 (so 0x07 under mask 0x17), every other register reads 0x00, and intN is high.
- R2: Opcode 0x03, an address byte, then any number of dummy bytes: the byte at the address is shifted out on miso, MSB first, during the third byte. Each later byte returns the next address, and the address wraps from 0x7F to 0x00.
- R3: Opcode 0x02, an address byte, then data bytes: each data byte is stored at the current address, which then advances with the same wrap as R2.
- R4: Opcode 0x05, address, mask byte, data byte: only the register bits set in the mask take the data value. All other bits keep their value, and any bytes after the data byte are ignored.
- R5: Opcode 0x40 + 2n, for n = 0..2, writes the bytes that follow starting at address 0x31 + 0x10·n and incrementing.
- R6: Opcode 0x90 (buffer 0) or 0x94 (buffer 1) returns bytes starting at address 0x61 or 0x71, beginning with the byte after the opcode. When chip select rises, flag bit 0 or bit 1 respectively of register 0x2C is cleared.
- R7: Opcode 0x80 | m sets bit 3 (value 0x08) of register 0x30 + 0x10·n for every n with bit n of m set, and leaves the other transmit control registers unchanged.
- R8: Bits 7:5 of register 0x0F request a mode (000 normal, 001 sleep, 010 loopback, 011 listen-only, 100 configuration). Register 0x0E reads that mode in bits 7:5, with zero below, one clock after the request is stored. Writes to 0x0E have no effect.
- R9: Opcode 0xC0 restores every register to its R1 value. The mode report follows one clock later.
- R10: intN is low exactly when register 0x2B AND register 0x2C is non-zero. Flag bits from 7 to 0 are message error, wake, error, transmit 2, transmit 1, transmit 0, receive 1, receive 0.
- R11: Raising chip select ends any command. An unfinished byte is dropped, and an unrecognised opcode (including 0x46) causes no register change before the next frame.
- R12: A flag bit raised on injFlagSet in the same cycle as a clear of that bit (from R6, a write or a masked update) ends up set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rstN | input | 1 | Synchronous reset, active low |
| sck | input | 1 | Serial clock from host, idle low |
| csN | input | 1 | Chip select, active low, frames a command |
| mosi | input | 1 | Serial data from host |
| miso | output | 1 | Serial data to host |
| injWe | input | 1 | Peripheral-side byte write enable |
| injAddr | input | 7 | Peripheral-side write address |
| injData | input | 8 | Peripheral-side write data |
| injFlagSet | input | 8 | Bits to OR into the flag register 0x2C |
| intN | output | 1 | Interrupt, low while an enabled flag is set |

## Verification
The collision that matters is the peripheral raising a receive flag in the same cycle as the host's receive-buffer read releasing that flag at chip-select rise. The bench sets flag bit 0, reads buffer 0, and holds injFlagSet bit 0 high for several clocks around the chip-select rise so that it overlaps the clear cycle whatever the synchroniser delay. The flag must then read back set, and intN must stay low with the interrupt enabled. The reference model applies the clear first and the set after, and any other ordering is judged a mismatch.

// File: rtl/canspi_pkg.sv
package canspi_pkg;
  parameter int ADDR_W = 7;
  parameter int DATA_W = 8;
  parameter int NUM_TX = 3;
  parameter int NUM_RX = 2;
  parameter int DEPTH  = 1 << ADDR_W;

  parameter logic [ADDR_W-1:0] STAT_ADDR  = 7'h0E;
  parameter logic [ADDR_W-1:0] CTRL_ADDR  = 7'h0F;
  parameter logic [ADDR_W-1:0] IE_ADDR    = 7'h2B;
  parameter logic [ADDR_W-1:0] IF_ADDR    = 7'h2C;
  parameter logic [ADDR_W-1:0] TX_BASE    = 7'h30;
  parameter logic [ADDR_W-1:0] RX_BASE    = 7'h60;
  parameter logic [ADDR_W-1:0] BUF_STRIDE = 7'h10;
  parameter logic [DATA_W-1:0] CTRL_RESET = 8'h87;
  parameter int TXREQ_BIT = 3;

  parameter logic [7:0] OPC_WRITE = 8'h02;
  parameter logic [7:0] OPC_READ  = 8'h03;
  parameter logic [7:0] OPC_BMOD  = 8'h05;
  parameter logic [7:0] OPC_RESET = 8'hC0;

  typedef enum logic [2:0] {
    ST_IDLE, ST_OPC, ST_ADDR, ST_MASK, ST_BMDATA, ST_WR, ST_RD, ST_SKIP
  } phase_t;

  typedef enum logic [1:0] { K_WR, K_RD, K_BM } kind_t;

  typedef struct packed {
    logic              wrEn;
    logic              bmEn;
    logic              rtsEn;
    logic              resetEn;
    logic [NUM_RX-1:0] rxClr;
    logic [NUM_TX-1:0] rtsMask;
    logic [ADDR_W-1:0] addr;
    logic [DATA_W-1:0] data;
    logic [DATA_W-1:0] mask;
  } strobe_t;
endpackage

// File: rtl/canspi_ctrl.sv
module canspi_ctrl
  import canspi_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              sckIn,
  input  logic              csNIn,
  input  logic              mosiIn,
  input  logic [DATA_W-1:0] rdData,
  output logic [ADDR_W-1:0] rdAddr,
  output strobe_t           strb,
  output logic              miso
);
  localparam int BIT_W = $clog2(DATA_W);

  logic [2:0] sckSh, csSh;
  logic [1:0] mosiSh;
  logic sckRise, sckFall, csActive, csFall, csRise, mosiBit, byteDone;
  logic [BIT_W-1:0]  bitCnt;
  logic [DATA_W-2:0] shIn;
  logic [DATA_W-1:0] rxByte, txShift, maskReg;
  logic [ADDR_W-1:0] ptr;
  logic [NUM_RX-1:0] rxPend;
  logic loadReq;
  phase_t state;
  kind_t  kind;

  function automatic logic isLoadTx(input logic [7:0] o);
    return (o[7:3] == 5'b01000) && !o[0] && (int'(o[2:1]) < NUM_TX);
  endfunction
  function automatic logic isReadRx(input logic [7:0] o);
    return (o[7:3] == 5'b10010) && (o[1:0] == 2'b00) && (int'(o[2]) < NUM_RX);
  endfunction
  function automatic logic isRts(input logic [7:0] o);
    return o[7:3] == 5'b10000;
  endfunction

  // pin synchronisers
  always_ff @(posedge clk) begin
    if (!rstN) begin
      sckSh  <= 3'b000;
      csSh   <= 3'b111;
      mosiSh <= 2'b00;
    end else begin
      sckSh  <= {sckSh[1:0], sckIn};
      csSh   <= {csSh[1:0], csNIn};
      mosiSh <= {mosiSh[0], mosiIn};
    end
  end

  assign sckRise  = sckSh[1] & ~sckSh[2];
  assign sckFall  = ~sckSh[1] & sckSh[2];
  assign csActive = ~csSh[1];
  assign csFall   = ~csSh[1] & csSh[2];
  assign csRise   = csSh[1] & ~csSh[2];
  assign mosiBit  = mosiSh[1];
  assign rxByte   = {shIn, mosiBit};
  assign byteDone = csActive && !csFall && sckRise && (bitCnt == BIT_W'(DATA_W-1));
  assign rdAddr   = ptr;
  assign miso     = txShift[DATA_W-1];

  // strobes towards the register file
  always_comb begin
    strb      = '0;
    strb.addr = ptr;
    strb.data = rxByte;
    strb.mask = maskReg;
    if (csRise) strb.rxClr = rxPend;
    if (byteDone) begin
      case (state)
        ST_OPC: begin
          if (rxByte == OPC_RESET) strb.resetEn = 1'b1;
          else if (isRts(rxByte)) begin
            strb.rtsEn   = 1'b1;
            strb.rtsMask = rxByte[NUM_TX-1:0];
          end
        end
        ST_BMDATA: strb.bmEn = 1'b1;
        ST_WR:     strb.wrEn = 1'b1;
        default: ;
      endcase
    end
  end

  // command sequencer
  always_ff @(posedge clk) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      kind    <= K_WR;
      bitCnt  <= '0;
      shIn    <= '0;
      txShift <= '0;
      maskReg <= '0;
      ptr     <= '0;
      rxPend  <= '0;
      loadReq <= 1'b0;
    end else if (!csActive) begin
      state   <= ST_IDLE;
      bitCnt  <= '0;
      loadReq <= 1'b0;
    end else if (csFall) begin
      state   <= ST_OPC;
      bitCnt  <= '0;
      txShift <= '0;
      rxPend  <= '0;
      loadReq <= 1'b0;
    end else begin
      if (sckRise) begin
        bitCnt <= bitCnt + 1'b1;
        shIn   <= {shIn[DATA_W-3:0], mosiBit};
      end
      if (sckFall && bitCnt != '0) txShift <= {txShift[DATA_W-2:0], 1'b0};
      if (loadReq) begin
        txShift <= rdData;
        ptr     <= ptr + 1'b1;
        loadReq <= 1'b0;
      end
      if (byteDone) begin
        case (state)
          ST_OPC: begin
            if (rxByte == OPC_WRITE) begin
              kind <= K_WR; state <= ST_ADDR;
            end else if (rxByte == OPC_READ) begin
              kind <= K_RD; state <= ST_ADDR;
            end else if (rxByte == OPC_BMOD) begin
              kind <= K_BM; state <= ST_ADDR;
            end else if (isLoadTx(rxByte)) begin
              ptr   <= TX_BASE + BUF_STRIDE * ADDR_W'(rxByte[2:1]) + ADDR_W'(1);
              state <= ST_WR;
            end else if (isReadRx(rxByte)) begin
              ptr     <= RX_BASE + BUF_STRIDE * ADDR_W'(rxByte[2]) + ADDR_W'(1);
              rxPend  <= NUM_RX'(1) << rxByte[2];
              loadReq <= 1'b1;
              state   <= ST_RD;
            end else begin
              state <= ST_SKIP;
            end
          end
          ST_ADDR: begin
            ptr <= rxByte[ADDR_W-1:0];
            case (kind)
              K_RD: begin state <= ST_RD; loadReq <= 1'b1; end
              K_BM: state <= ST_MASK;
              default: state <= ST_WR;
            endcase
          end
          ST_MASK: begin
            maskReg <= rxByte;
            state   <= ST_BMDATA;
          end
          ST_BMDATA: state <= ST_SKIP;
          ST_WR: ptr <= ptr + 1'b1;
          ST_RD: loadReq <= 1'b1;
          default: ;
        endcase
      end
    end
  end

  AST_FRAME_START: assert property (@(posedge clk) disable iff (!rstN)
    csFall |=> (state == ST_OPC) && (bitCnt == '0)); // R11
  AST_LOAD_ADVANCE: assert property (@(posedge clk) disable iff (!rstN)
    (loadReq && csActive && !csFall) |=> (ptr == $past(ptr) + 1'b1)); // R2
endmodule

// File: rtl/canspi_regs.sv
module canspi_regs
  import canspi_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           strb,
  input  logic [ADDR_W-1:0] rdAddr,
  output logic [DATA_W-1:0] rdData,
  input  logic              injWe,
  input  logic [ADDR_W-1:0] injAddr,
  input  logic [DATA_W-1:0] injData,
  input  logic [DATA_W-1:0] injFlagSet,
  output logic              intN
);
  localparam int MODE_W = 3;

  logic [DATA_W-1:0] mem [DEPTH];
  logic [MODE_W-1:0] modeCur;
  logic [DATA_W-1:0] ifNext;

  // flag register: clears apply first, peripheral sets last
  always_comb begin
    ifNext = mem[IF_ADDR];
    if (injWe && injAddr == IF_ADDR) ifNext = injData;
    if (strb.wrEn && strb.addr == IF_ADDR) ifNext = strb.data;
    if (strb.bmEn && strb.addr == IF_ADDR)
      ifNext = (ifNext & ~strb.mask) | (strb.data & strb.mask);
    ifNext[NUM_RX-1:0] = ifNext[NUM_RX-1:0] & ~strb.rxClr;
    ifNext = ifNext | injFlagSet;
  end

  always_ff @(posedge clk) begin
    if (!rstN || strb.resetEn) begin
      for (int i = 0; i < DEPTH; i++)
        mem[i] <= (ADDR_W'(i) == CTRL_ADDR) ? CTRL_RESET : '0;
    end else begin
      if (injWe) mem[injAddr] <= injData;
      if (strb.wrEn) mem[strb.addr] <= strb.data;
      if (strb.bmEn)
        mem[strb.addr] <= (mem[strb.addr] & ~strb.mask) | (strb.data & strb.mask);
      if (strb.rtsEn) begin
        for (int n = 0; n < NUM_TX; n++)
          if (strb.rtsMask[n])
            mem[TX_BASE + BUF_STRIDE * ADDR_W'(n)][TXREQ_BIT] <= 1'b1;
      end
      mem[IF_ADDR] <= ifNext;
    end
  end

  // mode report trails the request by one clock
  always_ff @(posedge clk) begin
    if (!rstN) modeCur <= CTRL_RESET[DATA_W-1 -: MODE_W];
    else       modeCur <= mem[CTRL_ADDR][DATA_W-1 -: MODE_W];
  end

  assign rdData = (rdAddr == STAT_ADDR) ? {modeCur, {(DATA_W-MODE_W){1'b0}}} : mem[rdAddr];
  assign intN   = ~|(mem[IE_ADDR] & mem[IF_ADDR]);

  AST_MODE_MIRROR: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> (modeCur == $past(mem[CTRL_ADDR][DATA_W-1 -: MODE_W]))); // R8
  AST_RX_RELEASE: assert property (@(posedge clk) disable iff (!rstN)
    ((|strb.rxClr) && !strb.resetEn) |=>
      ((mem[IF_ADDR][NUM_RX-1:0] & $past(strb.rxClr & ~injFlagSet[NUM_RX-1:0])) == '0)); // R6
  AST_TXREQ_SET: assert property (@(posedge clk) disable iff (!rstN)
    (strb.rtsEn && strb.rtsMask[0] && !strb.resetEn) |=> mem[TX_BASE][TXREQ_BIT]); // R7
  AST_RESET_CMD: assert property (@(posedge clk) disable iff (!rstN)
    strb.resetEn |=> (mem[CTRL_ADDR] == CTRL_RESET) && (mem[IF_ADDR] == '0)); // R9
  AST_MASKED_UPDATE: assert property (@(posedge clk) disable iff (!rstN)
    (strb.bmEn && !strb.resetEn && strb.addr != IF_ADDR && !(injWe && injAddr == strb.addr)) |=>
      (((mem[$past(strb.addr)] ^ $past(strb.data)) & $past(strb.mask)) == '0)); // R4
  AST_FLAG_SET_WINS: assert property (@(posedge clk) disable iff (!rstN)
    ((|injFlagSet) && !strb.resetEn) |=>
      ((mem[IF_ADDR] & $past(injFlagSet)) == $past(injFlagSet))); // R12
endmodule

// File: rtl/canspi_engine.sv
module canspi_engine
  import canspi_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              sck,
  input  logic              csN,
  input  logic              mosi,
  output logic              miso,
  input  logic              injWe,
  input  logic [ADDR_W-1:0] injAddr,
  input  logic [DATA_W-1:0] injData,
  input  logic [DATA_W-1:0] injFlagSet,
  output logic              intN
);
  strobe_t           strb;
  logic [ADDR_W-1:0] rdAddr;
  logic [DATA_W-1:0] rdData;

  canspi_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .sckIn(sck), .csNIn(csN), .mosiIn(mosi),
    .rdData(rdData), .rdAddr(rdAddr), .strb(strb), .miso(miso)
  );

  canspi_regs u_regs (
    .clk(clk), .rstN(rstN), .strb(strb), .rdAddr(rdAddr), .rdData(rdData),
    .injWe(injWe), .injAddr(injAddr), .injData(injData),
    .injFlagSet(injFlagSet), .intN(intN)
  );
endmodule

// File: tb/canspi_engine_tb.sv
module canspi_engine_tb;
  localparam int HALF = 8;
  localparam int STAT = 8'h0E, CTRL = 8'h0F, IE = 8'h2B, IFL = 8'h2C;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic rstN = 1'b0, sck = 1'b0, csN = 1'b1, mosi = 1'b0, miso, intN;
  logic injWe = 1'b0;
  logic [6:0] injAddr = '0;
  logic [7:0] injData = '0, injFlagSet = '0;

  canspi_engine u_dut (
    .clk(clk), .rstN(rstN), .sck(sck), .csN(csN), .mosi(mosi), .miso(miso),
    .injWe(injWe), .injAddr(injAddr), .injData(injData),
    .injFlagSet(injFlagSet), .intN(intN)
  );

  int checks = 0, errors = 0;
  logic [7:0] mdl [128];
  bit cmpOn = 0, done = 0;
  logic [7:0] txq[$];

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] mRd(input int a);
    if (a == STAT) return {mdl[CTRL][7:5], 5'b0};
    return mdl[a];
  endfunction

  function automatic logic expIntN();
    return ~|(mdl[IE] & mdl[IFL]);
  endfunction

  task automatic mReset();
    for (int i = 0; i < 128; i++) mdl[i] = 8'h00;
    mdl[CTRL] = 8'h87;
  endtask

  // interrupt pin compared against the model on every quiet clock
  always @(negedge clk)
    if (cmpOn) chk("R10 intN", {7'b0, intN}, {7'b0, expIntN()});

  task automatic clks(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic spiBits(input logic [7:0] tx, input int nb, output logic [7:0] rx);
    rx = '0;
    for (int i = 0; i < nb; i++) begin
      mosi = tx[7-i];
      clks(HALF);
      rx = {rx[6:0], miso};
      sck = 1'b1;
      clks(HALF);
      sck = 1'b0;
    end
  endtask

  task automatic csLow();
    cmpOn = 0;
    csN = 1'b0;
    clks(HALF);
  endtask

  task automatic csHigh();
    clks(HALF);
    csN = 1'b1;
    clks(HALF);
  endtask

  task automatic settle();
    clks(4);
    cmpOn = 1;
  endtask

  task automatic sendQ();
    logic [7:0] r;
    csLow();
    foreach (txq[i]) spiBits(txq[i], 8, r);
    csHigh();
  endtask

  task automatic spiRead(input string req, input int a, input int n);
    logic [7:0] r;
    csLow();
    spiBits(8'h03, 8, r);
    spiBits(8'(a), 8, r);
    for (int i = 0; i < n; i++) begin
      spiBits(8'h00, 8, r);
      chk(req, r, mRd((a + i) % 128));
    end
    csHigh();
    settle();
  endtask

  task automatic injByte(input int a, input logic [7:0] d);
    cmpOn = 0;
    injWe = 1'b1; injAddr = 7'(a); injData = d;
    clks(1);
    injWe = 1'b0;
    mdl[a] = d;
    settle();
  endtask

  task automatic injFlags(input logic [7:0] m);
    cmpOn = 0;
    injFlagSet = m;
    clks(1);
    injFlagSet = '0;
    mdl[IFL] = mdl[IFL] | m;
    settle();
  endtask

  task automatic readRx(input string req, input int n, input int cnt, input logic [7:0] holdSet);
    logic [7:0] r;
    int base;
    base = 8'h61 + 16 * n;
    csLow();
    spiBits(n == 0 ? 8'h90 : 8'h94, 8, r);
    for (int i = 0; i < cnt; i++) begin
      spiBits(8'h00, 8, r);
      chk(req, r, mRd(base + i));
    end
    injFlagSet = holdSet;
    csHigh();
    clks(HALF);
    injFlagSet = '0;
    mdl[IFL][n] = 1'b0;
    mdl[IFL] = mdl[IFL] | holdSet;
    settle();
  endtask

  initial begin
    logic [7:0] r;
    mReset();
    clks(5);
    rstN = 1'b1;
    settle();

    // R1 reset state
    chk("R1 intN after reset", {7'b0, intN}, 8'h01);
    spiRead("R1 status/ctrl", STAT, 2);
    spiRead("R1 flags", IE, 2);

    // R3 write burst, R2 read burst
    txq = {8'h02, 8'h20, 8'h11, 8'h22, 8'h33, 8'h44};
    sendQ();
    mdl[8'h20] = 8'h11; mdl[8'h21] = 8'h22; mdl[8'h22] = 8'h33; mdl[8'h23] = 8'h44;
    settle();
    spiRead("R3 R2 burst", 8'h1F, 6);

    // R2/R3 wrap 0x7F -> 0x00
    txq = {8'h02, 8'h7E, 8'hA1, 8'hB2, 8'hC3};
    sendQ();
    mdl[8'h7E] = 8'hA1; mdl[8'h7F] = 8'hB2; mdl[8'h00] = 8'hC3;
    settle();
    spiRead("R2 wrap", 8'h7E, 3);

    // R4 masked update
    txq = {8'h05, 8'h20, 8'hF0, 8'hA5, 8'hFF};
    sendQ();
    mdl[8'h20] = (mdl[8'h20] & 8'h0F) | (8'hA5 & 8'hF0);
    settle();
    spiRead("R4 masked", 8'h20, 2);

    // R5 load transmit buffer 1
    txq = {8'h42, 8'h01, 8'h02, 8'h03, 8'h04, 8'h05, 8'h06};
    sendQ();
    for (int i = 0; i < 6; i++) mdl[8'h41 + i] = 8'(i + 1);
    settle();
    spiRead("R5 load tx1", 8'h40, 8);

    // R6 receive buffers
    for (int i = 0; i < 6; i++) begin
      injByte(8'h61 + i, 8'(8'h70 + i));
      injByte(8'h71 + i, 8'(8'h90 + i));
    end
    injFlags(8'h03);
    readRx("R6 rx1 data", 1, 6, 8'h00);
    spiRead("R6 rx1 flag released", IFL, 1);

    // R10 interrupt enable; R6 release lifts intN
    txq = {8'h02, 8'h2B, 8'h01};
    sendQ();
    mdl[IE] = 8'h01;
    settle();
    chk("R10 intN low with rx0 enabled", {7'b0, intN}, 8'h00);
    readRx("R6 rx0 data", 0, 4, 8'h00);
    chk("R10 intN high after release", {7'b0, intN}, 8'h01);

    // R12 same-cycle set and release
    injFlags(8'h01);
    readRx("R12 rx0 data", 0, 2, 8'h01);
    spiRead("R12 flag kept", IFL, 1);
    chk("R12 intN stays low", {7'b0, intN}, 8'h00);

    // R7 send request for buffers 0 and 2
    txq = {8'h85};
    sendQ();
    mdl[8'h30] = mdl[8'h30] | 8'h08;
    mdl[8'h50] = mdl[8'h50] | 8'h08;
    settle();
    spiRead("R7 tx0 ctrl", 8'h30, 1);
    spiRead("R7 tx1 ctrl", 8'h40, 1);
    spiRead("R7 tx2 ctrl", 8'h50, 1);

    // R8 mode request and report
    txq = {8'h02, 8'h0F, 8'h40};
    sendQ();
    mdl[CTRL] = 8'h40;
    settle();
    spiRead("R8 loopback report", STAT, 2);
    txq = {8'h02, 8'h0E, 8'hFF};
    sendQ();
    settle();
    spiRead("R8 status write ignored", STAT, 1);

    // R11 partial byte, unknown opcodes
    csLow();
    spiBits(8'h02, 8, r);
    spiBits(8'h21, 8, r);
    spiBits(8'hEE, 5, r);
    csHigh();
    settle();
    spiRead("R11 partial byte dropped", 8'h21, 1);
    txq = {8'h11, 8'h21, 8'h55, 8'h66};
    sendQ();
    txq = {8'h46, 8'h77, 8'h88};
    sendQ();
    settle();
    spiRead("R11 unknown opcode", 8'h20, 4);
    spiRead("R11 unknown tx opcode", 8'h60, 3);

    // R9 reset command
    txq = {8'hC0};
    sendQ();
    mReset();
    settle();
    spiRead("R9 defaults", STAT, 2);
    spiRead("R9 cleared data", 8'h20, 2);
    spiRead("R9 cleared flags", IE, 2);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule